// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects thirteen interrupt sources and gives a CPU one request line together with the number of the winning source. Six of the sources are external pins, and four of those pins can be set to edge or level detection. Six sources are internal: a network controller, two timers, a millisecond tick and two serial ports. The last source is a non-maskable interrupt.

Priority is fixed and follows the source number. Index 0 is highest. The indices are assigned as follows:
- 0: NMI
- 1: external pin A
- 2: network
- 3, 4, 5: external pins B, C, D
- 6, 7: external pins E, F (also used as DMA completion)
- 8, 9: timers
- 10: millisecond tick
- 11, 12: serial ports

When the CPU acknowledges, the controller returns the vector. It then marks that source as in service, drops its edge latch and turns off the global enable. Software enables interrupts again with a set strobe and ends service with an end-of-interrupt write that carries the source number.

A simple configuration write loads one of two registers. `cfgSel`=0 selects the mask register, where bit i=1 masks source i. `cfgSel`=1 selects the mode register, where bit i=1 makes pin i level-sensitive.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the following hold: every maskable source is masked, all pins are in edge mode, no source is in service, the global enable is 0 (`ienOut`=0) and `irqOut`=0.
- R2: While `irqOut`=1, `vecOut` is the lowest index that is pending, not masked (NMI is never masked), not in service, and allowed by the global enable.
- R3: An index among 1, 3, 4 and 5 whose mode bit is 1 requests only while its input is high. The request disappears in the same cycle the input falls.
- R4: A source in edge mode latches a request on a rising input edge. The request stays after the input falls and is removed only by acknowledging that source. A high input with no new edge does not request again.
- R5: Indices 0, 6 and 7 are always edge-detected, whatever the value of their mode bit.
- R6: Mask bit i=1 stops maskable source i from requesting. Bit 0 has no effect on NMI.
- R7: A maskable source is presented only while the global enable is 1. `ienSet` sets the enable. An accepted acknowledge clears it, and the clear wins over a simultaneous `ienSet`.
- R8: NMI is presented and accepted while the global enable is 0.
- R9: A source whose in-service bit is set is not presented until an end-of-interrupt write with its index (`eoiWr`, `eoiSrc`) clears that bit.
- R10: `ackIn` while `irqOut`=0 changes nothing. In particular, the global enable stays set.
- R11: Internal sources (indices 2, 8–12) are always level-detected, whatever the value of their mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 13 | Raw source inputs, bit = source index |
| cfgWr | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 = mask register, 1 = mode register |
| cfgData | input | 13 | Configuration write data |
| ackIn | input | 1 | CPU acknowledge |
| eoiWr | input | 1 | End-of-interrupt write strobe |
| eoiSrc | input | 4 | Source index to clear from service |
| ienSet | input | 1 | Set the global enable |
| irqOut | output | 1 | Interrupt request to the CPU |
| vecOut | output | 4 | Index of the presented source |
| ienOut | output | 1 | Current global enable |

## Verification
The first sweep covers priority. Every pair of sources is raised together from a fresh reset, and the bench expects the smaller index, so an error in the ordering shows up at any position. A second pattern raises all thirteen sources and acknowledges them one by one. This exposes errors in the in-service blocking and in clearing the latches. After that, end-of-interrupt writes separate the sources that reassert from a held level from those that need a new edge. Further single-source pulses, which rise and then fall before acknowledge, separate latched requests from level requests in each mode class. Short patterns on the mask, the enable and acknowledge-without-request check that NMI bypasses the gating and that an acknowledge with nothing pending is ignored.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int NUM_SRC = 13;
  localparam int VEC_W   = $clog2(NUM_SRC);
  localparam int NMI_IDX = 0;
  // pins whose detection mode software may choose (indices 1,3,4,5)
  localparam logic [NUM_SRC-1:0] MODE_SEL_MASK   = 13'h003A;
  // internal sources, always level (indices 2,8..12)
  localparam logic [NUM_SRC-1:0] FIXED_LEVEL_MASK = 13'h1F04;

  typedef struct packed {
    logic ack;
    logic eoi;
    logic wrMask;
    logic wrMode;
  } ctrlStrobe_t;
endpackage

// File: rtl/ic_datapath.sv
module ic_datapath
  import vec_irq_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  srcIn,
  input  logic [N-1:0]  cfgData,
  input  ctrlStrobe_t   strobe,
  input  logic [VW-1:0] ackIdx,
  input  logic [VW-1:0] eoiIdx,
  output logic [N-1:0]  eligible
);
  logic [N-1:0] prevIn, edgeLatch, maskReg, modeReg, inService;
  logic [N-1:0] rise, levelSel, pending, maskEff, ackHot, eoiHot;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ackHot[i] = strobe.ack && (ackIdx == VW'(i));
      eoiHot[i] = strobe.eoi && (eoiIdx == VW'(i));
    end
    rise     = srcIn & ~prevIn;
    levelSel = FIXED_LEVEL_MASK | (modeReg & MODE_SEL_MASK);
    pending  = (levelSel & srcIn) | (~levelSel & edgeLatch);
    maskEff  = maskReg & ~(N'(1) << NMI_IDX);
    eligible = pending & ~maskEff & ~inService;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIn    <= '0;
      edgeLatch <= '0;
      maskReg   <= '1;
      modeReg   <= '0;
      inService <= '0;
    end else begin
      prevIn    <= srcIn;
      edgeLatch <= (edgeLatch & ~ackHot) | rise;
      inService <= (inService & ~eoiHot) | ackHot;
      if (strobe.wrMask) maskReg <= cfgData;
      if (strobe.wrMode) modeReg <= cfgData;
    end
  end
endmodule

// File: rtl/ic_control.sv
module ic_control
  import vec_irq_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  eligible,
  input  logic          ackIn,
  input  logic          eoiWr,
  input  logic          ienSet,
  input  logic          cfgWr,
  input  logic          cfgSel,
  output ctrlStrobe_t   strobe,
  output logic [VW-1:0] selIdx,
  output logic          irqOut,
  output logic          ienOut
);
  logic         ienFlag;
  logic [N-1:0] cand;

  always_comb begin
    cand = ienFlag ? eligible : (eligible & (N'(1) << NMI_IDX));
    selIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) selIdx = VW'(i);
    end
    irqOut        = |cand;
    strobe.ack    = ackIn && irqOut;
    strobe.eoi    = eoiWr;
    strobe.wrMask = cfgWr && !cfgSel;
    strobe.wrMode = cfgWr && cfgSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           ienFlag <= 1'b0;
    else if (strobe.ack) ienFlag <= 1'b0;
    else if (ienSet)     ienFlag <= 1'b1;
  end

  assign ienOut = ienFlag;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               cfgWr,
  input  logic               cfgSel,
  input  logic [NUM_SRC-1:0] cfgData,
  input  logic               ackIn,
  input  logic               eoiWr,
  input  logic [VEC_W-1:0]   eoiSrc,
  input  logic               ienSet,
  output logic               irqOut,
  output logic [VEC_W-1:0]   vecOut,
  output logic               ienOut
);
  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] eligible;

  ic_datapath #(.N(NUM_SRC), .VW(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .cfgData(cfgData),
    .strobe(strobe), .ackIdx(vecOut), .eoiIdx(eoiSrc), .eligible(eligible)
  );

  ic_control #(.N(NUM_SRC), .VW(VEC_W)) u_ctl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .ackIn(ackIn),
    .eoiWr(eoiWr), .ienSet(ienSet), .cfgWr(cfgWr), .cfgSel(cfgSel),
    .strobe(strobe), .selIdx(vecOut), .irqOut(irqOut), .ienOut(ienOut)
  );
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk
  import vec_irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             ackIn,
  input logic             ienSet,
  input logic             irqOut,
  input logic [VEC_W-1:0] vecOut,
  input logic             ienOut
);
  assert_vec_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (vecOut < VEC_W'(NUM_SRC)));

  assert_ack_clears_ien_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqOut) |=> !ienOut);

  assert_ien_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ienSet && !(ackIn && irqOut)) |=> ienOut);

  assert_only_nmi_when_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !ienOut) |-> (vecOut == VEC_W'(NMI_IDX)));

  assert_in_service_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqOut) |=> !(irqOut && vecOut == $past(vecOut)));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .ackIn(ackIn), .ienSet(ienSet),
  .irqOut(irqOut), .vecOut(vecOut), .ienOut(ienOut)
);

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  localparam int N = 13;
  logic clk = 1'b0;
  logic rstN, cfgWr, cfgSel, ackIn, eoiWr, ienSet;
  logic [N-1:0] srcIn, cfgData;
  logic [3:0] eoiSrc, vecOut;
  logic irqOut, ienOut;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .cfgWr(cfgWr), .cfgSel(cfgSel),
    .cfgData(cfgData), .ackIn(ackIn), .eoiWr(eoiWr), .eoiSrc(eoiSrc),
    .ienSet(ienSet), .irqOut(irqOut), .vecOut(vecOut), .ienOut(ienOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic doReset();
    rstN = 0; srcIn = '0; cfgWr = 0; cfgSel = 0; cfgData = '0;
    ackIn = 0; eoiWr = 0; eoiSrc = '0; ienSet = 0;
    cyc(); cyc();
    rstN = 1;
    cyc();
  endtask

  task automatic writeCfg(input logic sel, input logic [N-1:0] d);
    cfgWr = 1; cfgSel = sel; cfgData = d; cyc(); cfgWr = 0;
  endtask

  task automatic setIen();
    ienSet = 1; cyc(); ienSet = 0;
  endtask

  task automatic doAck();
    ackIn = 1; cyc(); ackIn = 0;
  endtask

  task automatic doEoi(input int idx);
    eoiWr = 1; eoiSrc = 4'(idx); cyc(); eoiWr = 0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    // R1 reset state
    doReset();
    chk("R1 irq after reset", int'(irqOut), 0);
    chk("R1 ien after reset", int'(ienOut), 0);
    srcIn[1] = 1; cyc();
    chk("R1 pin masked at reset", int'(irqOut), 0);

    // R2 exhaustive pairs
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        doReset();
        writeCfg(0, '0);
        setIen();
        srcIn[a] = 1; srcIn[b] = 1;
        cyc();
        chk("R2 pair irq", int'(irqOut), 1);
        chk("R2 pair vec", int'(vecOut), a);
      end
    end

    // R9 ack chain, then EOI behaviour (R4, R11)
    doReset();
    writeCfg(0, '0);
    setIen();
    srcIn = '1; cyc();
    for (int k = 0; k < N; k++) begin
      chk("R9 chain vec", int'(vecOut), k);
      doAck();
      setIen();
    end
    chk("R9 all in service", int'(irqOut), 0);
    doEoi(5); cyc();
    chk("R4 no edge no rerequest", int'(irqOut), 0);
    doEoi(8);
    chk("R11 level reasserts irq", int'(irqOut), 1);
    chk("R11 level reasserts vec", int'(vecOut), 8);

    // R3 level pin, R4 edge pin
    doReset();
    writeCfg(0, '0);
    writeCfg(1, 13'h0008);
    setIen();
    srcIn[3] = 1; cyc();
    chk("R3 level vec", int'(vecOut), 3);
    srcIn[3] = 0; #1;
    chk("R3 level drops", int'(irqOut), 0);
    srcIn[4] = 1; cyc(); srcIn[4] = 0; cyc();
    chk("R4 edge held irq", int'(irqOut), 1);
    chk("R4 edge held vec", int'(vecOut), 4);
    doAck(); doEoi(4); setIen();
    chk("R4 ack cleared latch", int'(irqOut), 0);

    // R5 fixed edge on 6, level option on 1
    doReset();
    writeCfg(0, '0);
    writeCfg(1, '1);
    setIen();
    srcIn[1] = 1; cyc(); srcIn[1] = 0; cyc();
    chk("R3 mode-all level pin drops", int'(irqOut), 0);
    srcIn[6] = 1; cyc(); srcIn[6] = 0; cyc();
    chk("R5 pin6 stays edge irq", int'(irqOut), 1);
    chk("R5 pin6 stays edge vec", int'(vecOut), 6);

    // R11 internal ignores edge mode
    doReset();
    writeCfg(0, '0);
    setIen();
    srcIn[9] = 1; cyc(); srcIn[9] = 0; cyc();
    chk("R11 internal not latched", int'(irqOut), 0);

    // R7 global enable
    doReset();
    writeCfg(0, '0);
    srcIn[2] = 1; cyc();
    chk("R7 disabled blocks", int'(irqOut), 0);
    setIen();
    chk("R7 enabled vec", int'(vecOut), 2);
    ienSet = 1; doAck(); ienSet = 0;
    chk("R7 ack beats set", int'(ienOut), 0);
    srcIn[8] = 1; cyc();
    chk("R7 timer blocked", int'(irqOut), 0);
    setIen();
    chk("R7 timer after set", int'(vecOut), 8);

    // R8 NMI with enable off and masks at reset
    doReset();
    srcIn[0] = 1; cyc();
    chk("R8 nmi irq", int'(irqOut), 1);
    chk("R8 nmi vec", int'(vecOut), 0);
    doAck();
    chk("R9 nmi in service", int'(irqOut), 0);
    doEoi(0); cyc();
    chk("R8 nmi needs edge", int'(irqOut), 0);
    srcIn[0] = 0; cyc(); srcIn[0] = 1; cyc();
    chk("R8 nmi new edge", int'(irqOut), 1);

    // R10 ack with nothing pending
    doReset();
    writeCfg(0, '0);
    setIen();
    doAck();
    chk("R10 ien kept", int'(ienOut), 1);
    srcIn[8] = 1; #1;
    chk("R10 later request vec", int'(vecOut), 8);

    // R6 masking
    doReset();
    writeCfg(0, '1);
    setIen();
    srcIn[0] = 1; srcIn[5] = 1; srcIn[10] = 1; cyc();
    chk("R6 nmi ignores mask", int'(vecOut), 0);
    doAck(); setIen();
    chk("R6 all masked", int'(irqOut), 0);
    writeCfg(0, 13'h1FDF);
    chk("R6 unmask pin5", int'(vecOut), 5);

    finishRun();
  end
endmodule